// File: doc/BRIEF.md
# Page Program Data Buffer

This block holds the data of one serial-flash page-program command while the command is still arriving, then writes that data into a modelled flash array once the command has ended. The serial front end hands it a start address and then a stream of bytes. The address picks the target page and the first byte column. Each byte is stored at the current column, and the column then steps forward. When the column passes the top of the page it wraps back to column 0 of the same page. A per-column valid mask records which columns received data. A long burst therefore keeps only the most recent byte for each column, and columns that were never written are not touched.

When chip select is released, the block checks whether the command may run. It runs only if an address was captured, at least one whole byte arrived, no partial byte was pending, the write-enable latch is set and the target page is not protected. If so, the block walks through the page one column per clock. Each written column gets the old array byte AND the latched byte, because programming can only clear bits. The busy flag stays high for a fixed number of clocks, and a one-clock pulse at the end tells the status logic to clear its write-enable latch. The array has a second read port so that its contents can be observed.

Top module: `page_prog_buffer`

## Requirements
- R1: After a synchronous reset, `busy` and `wel_clr` are 0 and `tgt_page` is 0. The array starts with every byte at FFh.
- R2: When `cmd_addr_vld` is high while idle, a new session opens. `tgt_page` becomes `cmd_addr[COL_W +: PG_W]` on the next clock, and the start column is `cmd_addr[COL_W-1:0]`. The valid mask is cleared.
- R3: Each accepted `data_vld` byte goes to the current column, and the column then increments. After column FFh the next byte goes to column 00h of the same page.
- R4: If more than 256 bytes arrive in one session, a later byte for a column replaces the earlier one. Only the last byte sent for each column is programmed.
- R5: Columns that received no byte in the session keep their previous array contents.
- R6: Programming starts only at the first clock that samples `sel_n` high after it was low. Each programmed column becomes the old array byte AND the latched byte.
- R7: If `page_lock` is 1 on that clock, nothing is programmed, `busy` stays 0 and `wel_clr` does not pulse.
- R8: If `wel` is 0 on that clock, nothing is programmed, `busy` stays 0 and `wel_clr` does not pulse.
- R9: If the session received no whole byte, or `part_byte` is 1 on that clock, nothing is programmed and `busy` stays 0.
- R10: An accepted commit raises `busy` on the clock that samples the `sel_n` rise. `busy` then stays high for exactly LEN = max(BUSY_CYC, 2^COL_W + 2) clocks.
- R11: `wel_clr` is high for exactly one clock, starting on the clock where `busy` falls after an accepted commit. It does not pulse at any other time.
- R12: While `busy` is high, address strobes, byte strobes and `sel_n` rises are ignored. The page, the latched data and the session state are unchanged when `busy` falls.
- R13: `rd_data` shows the array byte at `rd_addr = {page, column}` as sampled one clock earlier. Once `busy` is low, it shows the fully programmed contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select, active low; a rise ends the command |
| cmd_addr_vld | input | 1 | Strobe: start address of a program command |
| cmd_addr | input | ADDR_W | Start address (page in upper bits, column in low COL_W bits) |
| data_vld | input | 1 | Strobe: one whole data byte |
| data_byte | input | 8 | Data byte |
| part_byte | input | 1 | Front end holds a partial byte |
| wel | input | 1 | Write-enable latch state |
| page_lock | input | 1 | Protection decode result for `tgt_page` |
| rd_addr | input | PG_W+COL_W | Array observation address |
| rd_data | output | 8 | Array byte at the registered read address |
| tgt_page | output | PG_W | Page captured for the current session |
| busy | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | One-clock request to clear the write-enable latch |

## Verification
A wrong column pointer or a stale valid mask becomes visible only after the commit ends. It shows up as a wrong byte or an unexpectedly changed byte when the page is read back through `rd_data`, one clock after the address is applied. A faulty accept decision or a wrong cycle counter is visible at once: `busy` rises on a clock where it should not, or falls one or more clocks away from LEN. A wrongly gated strobe during `busy` changes `tgt_page` on the next clock, or corrupts the page seen by the next read-back.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WALK = 2'd1,
    PH_HOLD = 2'd2
  } ppb_phase_e;

  function automatic int unsigned ppb_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ppb_latch.sv
module ppb_latch #(
  parameter int ADDR_W = 24,
  parameter int COL_W  = 8,
  parameter int PG_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr,
  input  logic              data_vld,
  input  logic [7:0]        data_byte,
  input  logic              sess_end,
  input  logic [COL_W-1:0]  rd_col,
  output logic [PG_W-1:0]   page,
  output logic              armed,
  output logic              have_data,
  output logic [7:0]        lat_q,
  output logic              vld_q
);
  localparam int PAGE_BYTES = 1 << COL_W;

  logic [7:0]            lat_mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [COL_W-1:0]      col;
  logic                  wr_byte;
  logic                  open_sess;

  assign open_sess = accept && addr_vld;
  assign wr_byte   = accept && data_vld && armed && !addr_vld;

  // data storage: plain sync write / sync read, no reset
  always_ff @(posedge clk) begin
    if (wr_byte) lat_mem[col] <= data_byte;
    lat_q <= lat_mem[rd_col];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      have_data <= 1'b0;
      page      <= '0;
      col       <= '0;
      mask      <= '0;
      vld_q     <= 1'b0;
    end else begin
      vld_q <= mask[rd_col];
      if (open_sess) begin
        armed     <= 1'b1;
        have_data <= 1'b0;
        page      <= addr[COL_W +: PG_W];
        col       <= addr[COL_W-1:0];
        mask      <= '0;
      end else if (wr_byte) begin
        mask[col] <= 1'b1;
        col       <= col + 1'b1;
        have_data <= 1'b1;
      end
      if (sess_end) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/ppb_array.sv
module ppb_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    ra_q,
  input  logic [AW-1:0] rb,
  output logic [7:0]    rb_q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    ra_q <= mem[ra];
    rb_q <= mem[rb];
  end

endmodule

// File: rtl/ppb_sequencer.sv
module ppb_sequencer
  import ppb_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int LEN   = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             armed,
  input  logic             have_data,
  input  logic             part_byte,
  input  logic             wel,
  input  logic             page_lock,
  output logic             busy,
  output logic             wel_clr,
  output logic             sess_end,
  output logic [COL_W-1:0] walk_col,
  output logic             wr_pend,
  output logic [COL_W-1:0] wr_col
);
  localparam int CNT_W = $clog2(LEN + 1);
  localparam logic [COL_W-1:0] COL_LAST = '1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LEN - 1);

  ppb_phase_e       phase;
  logic             sel_q;
  logic             rise;
  logic             go;
  logic [CNT_W-1:0] cnt;

  assign busy     = (phase != PH_IDLE);
  assign rise     = sel_n && !sel_q;
  assign sess_end = rise && !busy;
  assign go       = sess_end && armed && have_data && !part_byte && wel && !page_lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      sel_q    <= 1'b1;
      cnt      <= '0;
      walk_col <= '0;
      wr_pend  <= 1'b0;
      wr_col   <= '0;
      wel_clr  <= 1'b0;
    end else begin
      sel_q   <= sel_n;
      wel_clr <= 1'b0;
      wr_pend <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (go) begin
            phase    <= PH_WALK;
            cnt      <= CNT_INIT;
            walk_col <= '0;
          end
        end
        PH_WALK: begin
          wr_pend  <= 1'b1;
          wr_col   <= walk_col;
          walk_col <= walk_col + 1'b1;
          cnt      <= cnt - 1'b1;
          if (walk_col == COL_LAST) phase <= PH_HOLD;
        end
        PH_HOLD: begin
          if (cnt == '0) begin
            phase   <= PH_IDLE;
            wel_clr <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/page_prog_buffer.sv
module page_prog_buffer
  import ppb_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int COL_W     = 8,
  parameter int NUM_PAGES = 4,
  parameter int BUSY_CYC  = 300,
  localparam int PG_W     = $clog2(NUM_PAGES),
  localparam int ARR_AW   = PG_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              cmd_addr_vld,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              data_vld,
  input  logic [7:0]        data_byte,
  input  logic              part_byte,
  input  logic              wel,
  input  logic              page_lock,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [PG_W-1:0]   tgt_page,
  output logic              busy,
  output logic              wel_clr
);
  localparam int PAGE_BYTES = 1 << COL_W;
  localparam int LEN        = int'(ppb_max(BUSY_CYC, PAGE_BYTES + 2));

  logic             armed, have_data, sess_end;
  logic [7:0]       lat_q, arr_q;
  logic             vld_q, wr_pend;
  logic [COL_W-1:0] walk_col, wr_col;
  logic             arr_we;
  logic [7:0]       arr_wd;

  ppb_latch #(.ADDR_W(ADDR_W), .COL_W(COL_W), .PG_W(PG_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .accept    (!busy),
    .addr_vld  (cmd_addr_vld),
    .addr      (cmd_addr),
    .data_vld  (data_vld),
    .data_byte (data_byte),
    .sess_end  (sess_end),
    .rd_col    (walk_col),
    .page      (tgt_page),
    .armed     (armed),
    .have_data (have_data),
    .lat_q     (lat_q),
    .vld_q     (vld_q)
  );

  ppb_sequencer #(.COL_W(COL_W), .LEN(LEN)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (sel_n),
    .armed     (armed),
    .have_data (have_data),
    .part_byte (part_byte),
    .wel       (wel),
    .page_lock (page_lock),
    .busy      (busy),
    .wel_clr   (wel_clr),
    .sess_end  (sess_end),
    .walk_col  (walk_col),
    .wr_pend   (wr_pend),
    .wr_col    (wr_col)
  );

  // programming only clears bits
  assign arr_we = wr_pend && vld_q;
  assign arr_wd = arr_q & lat_q;

  ppb_array #(.AW(ARR_AW)) u_array (
    .clk  (clk),
    .we   (arr_we),
    .wa   ({tgt_page, wr_col}),
    .wd   (arr_wd),
    .ra   ({tgt_page, walk_col}),
    .ra_q (arr_q),
    .rb   (rd_addr),
    .rb_q (rd_data)
  );

endmodule

// File: rtl/page_prog_buffer_chk.sv
module page_prog_buffer_chk #(
  parameter int LEN  = 300,
  parameter int PG_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            sel_n,
  input logic            wel,
  input logic            page_lock,
  input logic            busy,
  input logic            wel_clr,
  input logic            arr_we,
  input logic [PG_W-1:0] tgt_page
);
  int unsigned run;

  always_ff @(posedge clk) begin
    if (rst) run <= 0;
    else     run <= busy ? run + 1 : 0;
  end

  // R10
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == LEN));

  // R11
  wel_clr_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    wel_clr |-> (!busy && $past(busy)));

  // R11
  wel_clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    wel_clr |=> !wel_clr);

  // R6
  write_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  // R7
  start_allowed_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel && !page_lock && sel_n));

  // R12
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(tgt_page));

endmodule

bind page_prog_buffer page_prog_buffer_chk #(.LEN(LEN), .PG_W(PG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel_n     (sel_n),
  .wel       (wel),
  .page_lock (page_lock),
  .busy      (busy),
  .wel_clr   (wel_clr),
  .arr_we    (arr_we),
  .tgt_page  (tgt_page)
);

// File: tb/test_page_prog_buffer.sv
`timescale 1ns/1ps
module test_page_prog_buffer;
  localparam int ADDR_W = 24;
  localparam int COL_W  = 8;
  localparam int NPG    = 4;
  localparam int PG_W   = 2;
  localparam int AW     = PG_W + COL_W;
  localparam int PB     = 1 << COL_W;
  localparam int LEN    = 300;

  logic clk = 0;
  logic rst = 1;
  logic sel_n = 1, cmd_addr_vld = 0, data_vld = 0, part_byte = 0, wel = 0, page_lock = 0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [7:0] data_byte = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [PG_W-1:0] tgt_page;
  logic busy, wel_clr;

  always #5 clk = ~clk;

  page_prog_buffer #(.ADDR_W(ADDR_W), .COL_W(COL_W), .NUM_PAGES(NPG), .BUSY_CYC(LEN)) i_page_prog_buffer (
    .clk(clk), .rst(rst), .sel_n(sel_n), .cmd_addr_vld(cmd_addr_vld), .cmd_addr(cmd_addr),
    .data_vld(data_vld), .data_byte(data_byte), .part_byte(part_byte), .wel(wel),
    .page_lock(page_lock), .rd_addr(rd_addr), .rd_data(rd_data), .tgt_page(tgt_page),
    .busy(busy), .wel_clr(wel_clr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R13";

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] marr [1 << AW];
  logic [7:0] mlat [PB];
  bit         mmask [PB];
  bit m_busy, m_welclr, m_sel_prev, m_armed, m_have, m_rdok;
  int m_cnt, m_page, m_col;
  logic [7:0] m_exp_rd;

  initial for (int i = 0; i < (1 << AW); i++) marr[i] = 8'hFF;

  always @(posedge clk) begin
    bit rise, go;
    if (rst) begin
      m_busy = 0; m_welclr = 0; m_sel_prev = 1; m_armed = 0; m_have = 0;
      m_cnt = 0; m_page = 0; m_col = 0; m_rdok = 0;
      for (int c = 0; c < PB; c++) mmask[c] = 0;
    end else begin
      rise = sel_n && !m_sel_prev;
      m_sel_prev = sel_n;
      m_welclr = 0;
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0;
          m_welclr = 1;
          for (int c = 0; c < PB; c++)
            if (mmask[c]) marr[m_page * PB + c] = marr[m_page * PB + c] & mlat[c];
        end else m_cnt--;
      end else begin
        go = rise && m_armed && m_have && !part_byte && wel && !page_lock;
        if (cmd_addr_vld) begin
          m_armed = 1; m_have = 0;
          m_page = int'(cmd_addr[COL_W +: PG_W]);
          m_col = int'(cmd_addr[COL_W-1:0]);
          for (int c = 0; c < PB; c++) mmask[c] = 0;
        end else if (data_vld && m_armed) begin
          mlat[m_col] = data_byte;
          mmask[m_col] = 1;
          m_col = (m_col + 1) % PB;
          m_have = 1;
        end
        if (rise) m_armed = 0;
        if (go) begin m_busy = 1; m_cnt = LEN - 1; end
      end
      m_exp_rd = marr[rd_addr];
      m_rdok = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && m_rdok && !done) begin
      check(busy == m_busy, "R10", "busy", int'(busy), int'(m_busy));
      check(wel_clr == m_welclr, "R11", "wel_clr", int'(wel_clr), int'(m_welclr));
      check(int'(tgt_page) == m_page, "R2", "tgt_page", int'(tgt_page), m_page);
      if (!m_busy)
        check(rd_data == m_exp_rd, cur_req, "rd_data", int'(rd_data), int'(m_exp_rd));
    end
  end

  function automatic logic [7:0] pat(input int base, input int i);
    return 8'((base + i * 37) ^ (i >> 3));
  endfunction

  task automatic prog(input int page, input int col, input int nbytes, input int base, input bit part);
    @(negedge clk);
    sel_n = 0;
    cmd_addr_vld = 1;
    cmd_addr = ADDR_W'((page << COL_W) | col | (7 << 12 & 0));
    @(negedge clk);
    cmd_addr_vld = 0;
    for (int i = 0; i < nbytes; i++) begin
      data_vld = 1; data_byte = pat(base, i);
      @(negedge clk);
    end
    data_vld = 0;
    part_byte = part;
    sel_n = 1;
    @(negedge clk);
    part_byte = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic sweep(input int page);
    for (int c = 0; c < PB; c++) begin
      rd_addr = AW'(page * PB + c);
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(busy == 0, "R1", "busy in reset", int'(busy), 0);
    check(wel_clr == 0, "R1", "wel_clr in reset", int'(wel_clr), 0);
    check(tgt_page == 0, "R1", "tgt_page in reset", int'(tgt_page), 0);
    rst = 0;
    cur_req = "R13"; sweep(0);

    wel = 1;
    cur_req = "R6"; prog(0, 8'h10, 5, 8'h3C, 0); wait_idle(); sweep(0);
    cur_req = "R3"; prog(1, 8'hFE, 4, 8'h51, 0); wait_idle(); sweep(1);
    cur_req = "R4"; prog(2, 8'h80, 300, 8'hA7, 0); wait_idle(); sweep(2);
    cur_req = "R5"; prog(0, 8'h12, 6, 8'h0F, 0); wait_idle(); sweep(0);

    cur_req = "R7"; page_lock = 1; prog(3, 8'h00, 8, 8'h11, 0);
    page_lock = 0; wait_idle(); sweep(3);
    cur_req = "R8"; wel = 0; prog(3, 8'h20, 8, 8'h22, 0);
    wel = 1; wait_idle(); sweep(3);
    cur_req = "R9"; prog(3, 8'h40, 0, 8'h33, 0); wait_idle();
    prog(3, 8'h40, 2, 8'h44, 1); wait_idle(); sweep(3);

    cur_req = "R12"; prog(3, 8'h00, 3, 8'h5A, 0);
    repeat (5) @(negedge clk);
    sel_n = 0; cmd_addr_vld = 1; cmd_addr = ADDR_W'(1 << COL_W);
    @(negedge clk); cmd_addr_vld = 0; data_vld = 1; data_byte = 8'h00;
    @(negedge clk); data_vld = 0; sel_n = 1;
    @(negedge clk);
    wait_idle();
    @(negedge clk); sel_n = 0; @(negedge clk); sel_n = 1; @(negedge clk);
    wait_idle(); sweep(3); sweep(1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule